// File: doc/BRIEF.md
# Handshake Control and Status Unit

This unit is the register front end of an 8-bit parallel interface with two ports. A CPU reaches it over a byte-wide bus with chip select and a read/write strobe. The unit holds the general control word, the direction and control bytes for each port, and a service-request byte. Each of these can be written and read back at a fixed byte offset. The port data paths and the handshake sequencing belong to neighbouring blocks. They only read the stored values.

Four handshake pins come in from the outside world. Each pin passes through a synchroniser. A per-line sense bit then decides whether high or low counts as active. The status byte shows the live, polarity-corrected level of every line in its upper half. Its lower half holds one sticky flag per line. A flag sets when its line turns from inactive to active. Software clears a flag by writing a 1 to it. An interrupt request is raised when any flag is set and its per-line enable bit in the port control bytes is 1.

Top module: `hsk_ctrl_status`

## Requirements
- R1: Writes with `cs`=1 and `rnw`=0 store `wdata` on the next rising edge. The stored bytes read back at these offsets: general control 0x00, service request 0x02, port A direction 0x04, port B direction 0x06, port A control 0x0C, port B control 0x0E. Every other offset reads 0x00. The mode field (general control bits 7:6) is stored and read back unchanged.
- R2: `rdata` is combinational from the bus inputs and current state. It is 0x00 whenever `cs`=0 or `rnw`=0.
- R3: Synchronous reset `rst` clears every stored byte, every status flag and the synchroniser state to 0.
- R4: Status byte (offset 0x1A) bits 7:4 show the active state of lines 4,3,2,1. Line n uses `hPin[n-1]` and sense bit general control [n-1]. Sense 1 means active high and 0 means active low. A pin change appears in these bits after the second rising edge.
- R5: Status bits 3:0 are the sticky flags of lines 4,3,2,1. A flag sets on the inactive-to-active transition of its line. The flag is visible after the third rising edge that follows the pin change.
- R6: Writing the status offset with bit i = 1 clears flag i. Writing bit i = 0 leaves flag i unchanged.
- R7: If a set event and a clearing write hit the same flag on the same edge, the flag stays set.
- R8: General control bit 4 enables the pair of lines 1 and 2, and bit 5 enables the pair of lines 3 and 4. While a pair is disabled, its two flags are 0 and do not contribute to `irq`.
- R9: `irq` is high exactly when at least one flag is set together with its enable bit. The enable bits are port A control bit 1 for line 1, bit 2 for line 2, and port B control bit 1 for line 3, bit 2 for line 4. `irq` follows the flags combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| hPin | input | 4 | Handshake pins, bit 0 = line 1 |
| irq | output | 1 | Interrupt request |

## Verification
Read data and `irq` are combinational, so they are due in the same cycle as the bus inputs or flag change that drives them. Writes take effect on the next rising edge. A pin change reaches the level bits after two edges and the flags after three. The bench drives inputs just after the falling edge and compares against its cycle model at the next falling edge, so each result is sampled once its pipeline has settled. The same-edge set/clear case is timed so that the status write is sampled on exactly the third edge after the pin change.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int NUM_LINES = 4;
  localparam int HALF_W    = DATA_W / 2;

  localparam logic [ADDR_W-1:0] OFF_GEN  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_SVC  = 6'h02;
  localparam logic [ADDR_W-1:0] OFF_DIRA = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_DIRB = 6'h06;
  localparam logic [ADDR_W-1:0] OFF_CTLA = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_CTLB = 6'h0E;
  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h1A;

  localparam int GEN_EN_LO = 4;  // enables lines 1 and 2
  localparam int GEN_EN_HI = 5;  // enables lines 3 and 4
  localparam int IE_FIRST  = 1;  // interrupt enable of first line in a port control byte
  localparam int IE_SECOND = 2;  // interrupt enable of second line

  typedef enum logic [2:0] {
    SEL_NONE, SEL_GEN, SEL_SVC, SEL_DIRA, SEL_DIRB, SEL_CTLA, SEL_CTLB, SEL_STAT
  } regSel_e;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regSel_e sel;
  } busStrobe_t;
endpackage

// File: rtl/hsk_bus_ctrl.sv
module hsk_bus_ctrl
  import hsk_pkg::*;
(
  input  logic              cs,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  output busStrobe_t        strobe
);
  regSel_e selNow;

  always_comb begin
    unique case (addr)
      OFF_GEN:  selNow = SEL_GEN;
      OFF_SVC:  selNow = SEL_SVC;
      OFF_DIRA: selNow = SEL_DIRA;
      OFF_DIRB: selNow = SEL_DIRB;
      OFF_CTLA: selNow = SEL_CTLA;
      OFF_CTLB: selNow = SEL_CTLB;
      OFF_STAT: selNow = SEL_STAT;
      default:  selNow = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.wrEn = cs & ~rnw;
    strobe.rdEn = cs & rnw;
    strobe.sel  = selNow;
  end
endmodule

// File: rtl/hsk_line_sync.sv
module hsk_line_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] prevOut
);
  localparam int DEPTH = STAGES + 1;
  logic [WIDTH-1:0] chain [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= pinIn;
  end

  genvar k;
  generate
    for (k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[k] <= '0;
        else     chain[k] <= chain[k-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
  assign prevOut = chain[STAGES];
endmodule

// File: rtl/hsk_status_dp.sv
module hsk_status_dp
  import hsk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  busStrobe_t           strobe,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] syncLvl,
  input  logic [NUM_LINES-1:0] prevLvl,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irq,
  output logic [DATA_W-1:0]    genCtl,
  output logic [NUM_LINES-1:0] flags
);
  logic [DATA_W-1:0]    svcReg, dirA, dirB, ctlA, ctlB;
  logic [NUM_LINES-1:0] sense, activeNow, activePrev, riseEv;
  logic [NUM_LINES-1:0] pairEn, clrMask, intEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      genCtl <= '0;
      svcReg <= '0;
      dirA   <= '0;
      dirB   <= '0;
      ctlA   <= '0;
      ctlB   <= '0;
    end else if (strobe.wrEn) begin
      case (strobe.sel)
        SEL_GEN:  genCtl <= wdata;
        SEL_SVC:  svcReg <= wdata;
        SEL_DIRA: dirA   <= wdata;
        SEL_DIRB: dirB   <= wdata;
        SEL_CTLA: ctlA   <= wdata;
        SEL_CTLB: ctlB   <= wdata;
        default: ;
      endcase
    end
  end

  assign sense      = genCtl[NUM_LINES-1:0];
  assign activeNow  = ~(syncLvl ^ sense);
  assign activePrev = ~(prevLvl ^ sense);
  assign riseEv     = activeNow & ~activePrev;
  assign pairEn     = {genCtl[GEN_EN_HI], genCtl[GEN_EN_HI], genCtl[GEN_EN_LO], genCtl[GEN_EN_LO]};
  assign clrMask    = (strobe.wrEn && strobe.sel == SEL_STAT) ? wdata[NUM_LINES-1:0] : '0;
  assign intEn      = {ctlB[IE_SECOND], ctlB[IE_FIRST], ctlA[IE_SECOND], ctlA[IE_FIRST]};

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= pairEn & (riseEv | (flags & ~clrMask));
  end

  assign irq = |(flags & intEn);

  always_comb begin
    rdata = '0;
    if (strobe.rdEn) begin
      case (strobe.sel)
        SEL_GEN:  rdata = genCtl;
        SEL_SVC:  rdata = svcReg;
        SEL_DIRA: rdata = dirA;
        SEL_DIRB: rdata = dirB;
        SEL_CTLA: rdata = ctlA;
        SEL_CTLB: rdata = ctlB;
        SEL_STAT: rdata = {activeNow, flags};
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/hsk_ctrl_status.sv
module hsk_ctrl_status
  import hsk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs,
  input  logic                 rnw,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_LINES-1:0] hPin,
  output logic                 irq
);
  busStrobe_t           strobe;
  logic [NUM_LINES-1:0] syncLvl, prevLvl, statFlags;
  logic [DATA_W-1:0]    genCtl;

  hsk_bus_ctrl u_ctrl (
    .cs(cs), .rnw(rnw), .addr(addr), .strobe(strobe)
  );

  hsk_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pinIn(hPin), .syncOut(syncLvl), .prevOut(prevLvl)
  );

  hsk_status_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wdata(wdata),
    .syncLvl(syncLvl), .prevLvl(prevLvl), .rdata(rdata), .irq(irq),
    .genCtl(genCtl), .flags(statFlags)
  );
endmodule

// File: rtl/hsk_ctrl_status_chk.sv
module hsk_ctrl_status_chk
  import hsk_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 cs,
  input logic                 rnw,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic                 irq,
  input logic [DATA_W-1:0]    genCtl,
  input logic [NUM_LINES-1:0] flags
);
  logic statWr;
  assign statWr = cs && !rnw && (addr == OFF_STAT);

  // R2
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs && rnw) |-> rdata == '0);

  // R9
  quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |-> !irq);

  // R8
  pair_lo_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!genCtl[GEN_EN_LO]) |-> flags[1:0] == 2'b00);

  // R8
  pair_hi_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!genCtl[GEN_EN_HI]) |-> flags[3:2] == 2'b00);

  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_flag
      localparam int EN_BIT = (i < 2) ? GEN_EN_LO : GEN_EN_HI;
      // R6
      flag_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags[i]) |-> ($past(statWr && wdata[i]) || $past(!genCtl[EN_BIT])));
      // R5
      flag_set_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[i]) |-> $past(genCtl[EN_BIT]));
    end
  endgenerate
endmodule

bind hsk_ctrl_status hsk_ctrl_status_chk u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rnw(rnw), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq(irq), .genCtl(genCtl), .flags(statFlags)
);

// File: tb/tb_hsk_ctrl_status.sv
module tb_hsk_ctrl_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0;
  logic       rnw = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] hPin = 4'hF;
  logic       irq;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hsk_ctrl_status dut (
    .clk(clk), .rst(rst), .cs(cs), .rnw(rnw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hPin(hPin), .irq(irq)
  );

  // Behavioural reference model
  bit [7:0] mGen, mSvc, mDirA, mDirB, mCtlA, mCtlB;
  bit [3:0] mFlag;
  bit [3:0] hist[$];

  function automatic bit lineActive(bit raw, int line);
    return mGen[line] ? raw : !raw;
  endfunction

  function automatic bit [7:0] expRead();
    bit [7:0] v;
    v = 8'h00;
    if (cs && rnw) begin
      case (addr)
        6'h00: v = mGen;
        6'h02: v = mSvc;
        6'h04: v = mDirA;
        6'h06: v = mDirB;
        6'h0C: v = mCtlA;
        6'h0E: v = mCtlB;
        6'h1A: begin
          for (int n = 0; n < 4; n++) v[4+n] = lineActive(hist[1][n], n);
          v[3:0] = mFlag;
        end
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

  function automatic bit expIrq();
    bit [3:0] en;
    en = {mCtlB[2], mCtlB[1], mCtlA[2], mCtlA[1]};
    return |(mFlag & en);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {mGen, mSvc, mDirA, mDirB, mCtlA, mCtlB} = '0;
      mFlag = '0;
      hist = '{4'h0, 4'h0, 4'h0};
    end else begin
      for (int n = 0; n < 4; n++) begin
        bit en, ev, clr;
        en  = (n < 2) ? mGen[4] : mGen[5];
        ev  = lineActive(hist[1][n], n) && !lineActive(hist[2][n], n);
        clr = cs && !rnw && addr == 6'h1A && wdata[n];
        mFlag[n] = en && (ev || (mFlag[n] && !clr));
      end
      if (cs && !rnw) begin
        case (addr)
          6'h00: mGen  = wdata;
          6'h02: mSvc  = wdata;
          6'h04: mDirA = wdata;
          6'h06: mDirB = wdata;
          6'h0C: mCtlA = wdata;
          6'h0E: mCtlB = wdata;
          default: ;
        endcase
      end
      hist.push_front(hPin);
      void'(hist.pop_back());
    end
  end

  // Compare on every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit [7:0] er;
      er = expRead();
      checks++;
      if (rdata !== er) begin
        errs++;
        if (!(cs && rnw)) $display("FAIL R2 idle rdata: actual=%02h expected=%02h", rdata, er);
        else if (addr == 6'h1A) $display("FAIL R4/R5 status read: actual=%02h expected=%02h", rdata, er);
        else $display("FAIL R1 read @%02h: actual=%02h expected=%02h", addr, rdata, er);
      end
      checks++;
      if (irq !== expIrq()) begin
        errs++;
        $display("FAIL R9 irq: actual=%0b expected=%0b", irq, expIrq());
      end
    end
  end

  task automatic busWrite(input bit [5:0] a, input bit [7:0] d);
    @(negedge clk); #2;
    cs = 1; rnw = 0; addr = a; wdata = d;
    @(negedge clk); #2;
    cs = 0; rnw = 1; wdata = '0;
  endtask

  task automatic readChk(input bit [5:0] a, input bit [7:0] exp, input string tag);
    @(negedge clk); #2;
    cs = 1; rnw = 1; addr = a;
    @(negedge clk);
    checks++;
    if (rdata !== exp) begin
      errs++;
      $display("FAIL %s read @%02h: actual=%02h expected=%02h", tag, a, rdata, exp);
    end
    #2; cs = 0;
  endtask

  task automatic irqChk(input bit exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errs++;
      $display("FAIL %s irq: actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  task automatic setPin(input int b, input bit v);
    @(negedge clk); #2;
    hPin[b] = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2 rst = 0;

    // R3: reset state
    readChk(6'h00, 8'h00, "R3");
    readChk(6'h1A, 8'h00, "R3");
    readChk(6'h0C, 8'h00, "R3");

    // R1: register map readback
    busWrite(6'h00, 8'h3F);
    readChk(6'h00, 8'h3F, "R1");
    readChk(6'h1A, 8'hF0, "R4");
    busWrite(6'h02, 8'h5A); readChk(6'h02, 8'h5A, "R1");
    busWrite(6'h04, 8'hA5); readChk(6'h04, 8'hA5, "R1");
    busWrite(6'h06, 8'h3C); readChk(6'h06, 8'h3C, "R1");
    busWrite(6'h0C, 8'h02); readChk(6'h0C, 8'h02, "R1");
    busWrite(6'h0E, 8'h06); readChk(6'h0E, 8'h06, "R1");
    readChk(6'h10, 8'h00, "R1");
    readChk(6'h12, 8'h00, "R1");

    // R5: rising edge on line 1 (active high) sets its flag
    setPin(0, 0); settle();
    readChk(6'h1A, 8'hE0, "R4");
    setPin(0, 1); settle();
    readChk(6'h1A, 8'hF1, "R5");
    irqChk(1'b1, "R9");
    busWrite(6'h0C, 8'h04);
    irqChk(1'b0, "R9");
    busWrite(6'h0C, 8'h06);

    // R6: write 0 keeps, write 1 clears
    busWrite(6'h1A, 8'h00);
    readChk(6'h1A, 8'hF1, "R6");
    busWrite(6'h1A, 8'h01);
    readChk(6'h1A, 8'hF0, "R6");
    irqChk(1'b0, "R6");

    // R7: clear-write on the same edge as the set event
    setPin(1, 0); settle();
    setPin(1, 1);
    @(negedge clk);
    busWrite(6'h1A, 8'h02);
    readChk(6'h1A, 8'hF2, "R7");
    irqChk(1'b1, "R7");
    busWrite(6'h1A, 8'h02);
    readChk(6'h1A, 8'hF0, "R6");

    // R4/R5: line 3 active low
    busWrite(6'h00, 8'h3B);
    readChk(6'h1A, 8'hB0, "R4");
    setPin(2, 0); settle();
    readChk(6'h1A, 8'hF4, "R5");
    irqChk(1'b1, "R9");

    // R8: disabling the upper pair drops its flags and irq
    busWrite(6'h00, 8'h1B);
    readChk(6'h1A, 8'hF0, "R8");
    irqChk(1'b0, "R8");
    setPin(3, 0); settle();
    setPin(3, 1); settle();
    readChk(6'h1A, 8'hF0, "R8");
    busWrite(6'h00, 8'h3B);
    readChk(6'h1A, 8'hF0, "R8");

    // R1: mode field stored; R4 all lines active low
    busWrite(6'h00, 8'hC0);
    readChk(6'h00, 8'hC0, "R1");
    readChk(6'h1A, 8'h40, "R4");

    // R2: deselected bus reads zero
    @(negedge clk); #2; cs = 0; addr = 6'h00;
    @(negedge clk);
    checks++;
    if (rdata !== 8'h00) begin
      errs++;
      $display("FAIL R2 deselected: actual=%02h expected=00", rdata);
    end

    settle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule